// File: doc/BRIEF.md
# Snooping Write-Through Cache Controller

This block sits between a 32-bit processor request port and a single system-bus master port and keeps a 32 KB local copy of memory. It owns the tag directory, the line storage and the hit, miss and replacement logic. A static configuration input chooses how the same storage is organised: one way of 2048 lines, or two ways of 1024 sets. In both cases a line is 16 bytes (four 32-bit words).

Cacheable reads that hit complete in the cycle they are presented. Misses fetch the whole line from the bus as four single-word reads. Writes are write-through with no allocation on a miss. Every write, cacheable or not, goes into a posted buffer and completes in zero wait states. The buffer drains to the bus in order. A read that needs the bus first waits until the buffer is empty. Requests flagged non-cacheable use the bus directly and never create or change a line.

A snoop input reports writes made by other bus masters. Any valid line that matches is invalidated. If a snoop matches the line being fetched, that line is installed as invalid.

Top module: `cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `bus_req` is low and `cpu_ready` is low while `cpu_req` is low.
- R2: A cacheable read whose line is valid raises `cpu_ready` in the same cycle, with the cached word on `cpu_rdata`, and issues no bus transfer.
- R3: A write, cacheable or not, is accepted in the cycle it is presented (`cpu_ready` high) while the 4-entry posted buffer has room. Buffered writes leave on the bus as single-word writes in the order they were accepted.
- R4: A cacheable write that hits updates the addressed word of the cached line. A cacheable write that misses leaves the cache unchanged, so a later read of that line misses.
- R5: A cacheable read miss fetches the 16-byte line with four single-word bus reads at ascending word addresses (byte offsets 0, 4, 8, 12). On the last acknowledge it returns the requested word and installs the line.
- R6: A read that needs the bus (miss or non-cacheable) starts no bus read while the posted buffer holds any entry, so it observes every earlier write.
- R7: A snoop pulse (`snp_valid` high for one cycle with line address `snp_line` = address bits 31:4) invalidates any valid line with that address. Lines with other tags in the same set are unaffected.
- R8: If a snoop matches the line being fetched at any time during the fill, including the last cycle, the fill still returns its word but the line is left invalid.
- R9: Bus transfers are single-word. `bus_req` stays high with stable `bus_addr` and `bus_we` until a one-cycle `bus_ack`. `bus_we` = 1 marks a write.
- R10: A non-cacheable read (`cpu_nc` = 1) makes exactly one bus read and allocates nothing. A non-cacheable write is posted but never updates a cached word.
- R11: With `cfg_two_way` = 0 the line index is address bits 14:4. Two addresses that differ only above bit 14 evict each other. Addresses differing in bit 14 coexist.
- R12: With `cfg_two_way` = 1 the set index is address bits 13:4 with two ways. A miss replaces the least recently used way, and recency is updated on every hit and fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_two_way | input | 1 | 1 = two-way sets, 0 = one way; change only under reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_nc | input | 1 | Request bypasses the cache |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = bus write |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer done, one cycle |
| snp_valid | input | 1 | Another master wrote memory |
| snp_line | input | 28 | Line address (bits 31:4) of that write |

## Verification
Reads are tried as cold misses, repeated hits and hits on another word of a freshly filled line. These separate a working fill and lookup from one that only echoes the bus. The same three conflicting addresses are replayed in both organisations: the one-way case must evict where the two-way case keeps the recently used line, which exposes wrong index bits and a wrong LRU choice. Writes are applied as hits, misses, non-cacheable writes to a cached line and a back-to-back burst, which tells write-through apart from allocation, bypass and reordering. Snoops aimed at a cached line, at another tag of the same set and at a line mid-fill check both invalidation and its precision.

// File: rtl/cache_pkg.sv
package cache_pkg;
    parameter int ADDR_W     = 32;
    parameter int DATA_W     = 32;
    parameter int LINE_WORDS = 4;
    parameter int LINES      = 2048;

    localparam int OFF_W  = $clog2(LINE_WORDS * DATA_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int LA_W   = ADDR_W - OFF_W;
    localparam int SLOT_W = $clog2(LINES);
    localparam int SET_W  = SLOT_W - 1;
    localparam int TAG_W  = LA_W - SET_W;

    typedef logic [LA_W-1:0] line_addr_t;
    typedef logic [LINE_WORDS-1:0][DATA_W-1:0] line_t;

    typedef enum logic [1:0] {ST_IDLE, ST_NCRD, ST_FILL} ctl_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wb_entry_t;

    // Storage slot: one-way uses all index bits, two-way prepends the way.
    function automatic logic [SLOT_W-1:0] slot_of(input line_addr_t la,
                                                  input logic way,
                                                  input logic two_way);
        return two_way ? {way, la[SET_W-1:0]} : la[SLOT_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input line_addr_t la);
        return la[LA_W-1 -: TAG_W];
    endfunction

    function automatic logic [SET_W-1:0] set_of(input line_addr_t la);
        return la[SET_W-1:0];
    endfunction
endpackage

// File: rtl/cache_dir.sv
module cache_dir
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              two_way,
    input  line_addr_t        look_la,
    output logic              look_hit,
    output logic              look_way,
    output logic [SLOT_W-1:0] look_slot,
    output logic              victim_way,
    input  logic              snp_valid,
    input  line_addr_t        snp_la,
    input  logic              fill_en,
    input  line_addr_t        fill_la,
    input  logic              fill_way,
    input  logic              fill_valid,
    input  logic              touch_en,
    input  line_addr_t        touch_la,
    input  logic              touch_way
);
    localparam int SETS = LINES / 2;

    logic [TAG_W-1:0] tags [LINES];
    logic [LINES-1:0] valid;
    logic [SETS-1:0]  lru;     // way to replace next
    logic [1:0]       look_h;
    logic [1:0]       snp_h;

    always_comb begin
        for (int w = 0; w < 2; w++) begin
            look_h[w] = valid[slot_of(look_la, w[0], two_way)] &&
                        tags[slot_of(look_la, w[0], two_way)] == tag_of(look_la);
            snp_h[w]  = valid[slot_of(snp_la, w[0], two_way)] &&
                        tags[slot_of(snp_la, w[0], two_way)] == tag_of(snp_la);
        end
        look_hit   = |look_h;
        look_way   = two_way && !look_h[0];
        look_slot  = slot_of(look_la, look_way, two_way);
        victim_way = two_way && lru[set_of(look_la)];
    end

    always_ff @(posedge clk) begin
        if (fill_en)
            tags[slot_of(fill_la, fill_way, two_way)] <= tag_of(fill_la);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            lru   <= '0;
        end else begin
            if (fill_en)
                valid[slot_of(fill_la, fill_way, two_way)] <= fill_valid;
            if (touch_en && two_way)
                lru[set_of(touch_la)] <= ~touch_way;
            if (snp_valid) begin
                for (int w = 0; w < 2; w++)
                    if (snp_h[w]) valid[slot_of(snp_la, w[0], two_way)] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cache_data.sv
module cache_data
    import cache_pkg::*;
(
    input  logic                  clk,
    input  logic [SLOT_W-1:0]     rd_slot,
    output line_t                 rd_line,
    input  logic                  wr_en,
    input  logic [SLOT_W-1:0]     wr_slot,
    input  logic [LINE_WORDS-1:0] wr_mask,
    input  line_t                 wr_line
);
    line_t lines [LINES];

    assign rd_line = lines[rd_slot];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LINE_WORDS; i++)
                if (wr_mask[i]) lines[wr_slot][i] <= wr_line[i];
        end
    end
endmodule

// File: rtl/post_wbuf.sv
module post_wbuf
    import cache_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wb_entry_t push_ent,
    input  logic      pop,
    output wb_entry_t head,
    output logic      empty,
    output logic      full,
    output logic [CW-1:0] level
);
    wb_entry_t      q [DEPTH];
    logic [PW-1:0]  rd_p, wr_p;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = q[rd_p];
    assign empty = (level == '0);
    assign full  = (level == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (push) q[wr_p] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p  <= '0;
            wr_p  <= '0;
            level <= '0;
        end else begin
            if (push) wr_p <= nxt(wr_p);
            if (pop)  rd_p <= nxt(rd_p);
            level <= level + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_two_way,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_nc,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              snp_valid,
    input  logic [LA_W-1:0]   snp_line
);
    localparam int CW = $clog2(WB_DEPTH + 1);

    ctl_state_e          state;
    line_addr_t          fill_la;
    logic                fill_way;
    logic [WSEL_W-1:0]   fill_cnt;
    logic                fill_snooped;
    line_t               fill_line, asm_line, rd_line, wr_line;
    logic [LINE_WORDS-1:0] wr_mask;
    logic [SLOT_W-1:0]   look_slot, wr_slot;
    logic                look_hit, look_way, victim_way;
    wb_entry_t           wb_head;
    logic                wb_empty, wb_full, wb_pop;
    logic [CW-1:0]       wb_level;

    line_addr_t          cpu_la;
    logic [WSEL_W-1:0]   cpu_wsel;
    logic st_idle, st_fill, rd_hit, wr_acc, wr_hit, start_miss, fill_last, snp_on_fill;

    assign cpu_la   = cpu_addr[ADDR_W-1:OFF_W];
    assign cpu_wsel = cpu_addr[OFF_W-1:2];
    assign st_idle  = (state == ST_IDLE);
    assign st_fill  = (state == ST_FILL);

    assign rd_hit     = st_idle && cpu_req && !cpu_we && !cpu_nc && look_hit;
    assign wr_acc     = st_idle && cpu_req && cpu_we && !wb_full;
    assign wr_hit     = wr_acc && !cpu_nc && look_hit;
    assign start_miss = st_idle && cpu_req && !cpu_we && !(!cpu_nc && look_hit) && wb_empty;
    assign fill_last  = st_fill && bus_ack && (fill_cnt == WSEL_W'(LINE_WORDS - 1));
    assign snp_on_fill = snp_valid && (snp_line == fill_la);
    assign wb_pop     = st_idle && bus_ack;

    always_comb begin
        asm_line           = fill_line;
        asm_line[fill_cnt] = bus_rdata;
    end

    cache_dir dir_i (
        .clk(clk), .rst(rst), .two_way(cfg_two_way),
        .look_la(cpu_la), .look_hit(look_hit), .look_way(look_way),
        .look_slot(look_slot), .victim_way(victim_way),
        .snp_valid(snp_valid), .snp_la(snp_line),
        .fill_en(fill_last), .fill_la(fill_la), .fill_way(fill_way),
        .fill_valid(!(fill_snooped || snp_on_fill)),
        .touch_en(rd_hit || wr_hit || fill_last),
        .touch_la(fill_last ? fill_la : cpu_la),
        .touch_way(fill_last ? fill_way : look_way)
    );

    always_comb begin
        wr_slot = look_slot;
        wr_mask = '0;
        wr_line = {LINE_WORDS{cpu_wdata}};
        if (fill_last) begin
            wr_slot = slot_of(fill_la, fill_way, cfg_two_way);
            wr_mask = '1;
            wr_line = asm_line;
        end else if (wr_hit) begin
            wr_mask[cpu_wsel] = 1'b1;
        end
    end

    cache_data data_i (
        .clk(clk), .rd_slot(look_slot), .rd_line(rd_line),
        .wr_en(fill_last || wr_hit), .wr_slot(wr_slot),
        .wr_mask(wr_mask), .wr_line(wr_line)
    );

    post_wbuf #(.DEPTH(WB_DEPTH)) wbuf_i (
        .clk(clk), .rst(rst),
        .push(wr_acc), .push_ent('{addr: cpu_addr, data: cpu_wdata}),
        .pop(wb_pop), .head(wb_head),
        .empty(wb_empty), .full(wb_full), .level(wb_level)
    );

    // Processor side
    always_comb begin
        cpu_ready = rd_hit || wr_acc || fill_last || (state == ST_NCRD && bus_ack);
        cpu_rdata = '0;
        if (rd_hit)                cpu_rdata = rd_line[cpu_wsel];
        else if (state == ST_NCRD) cpu_rdata = bus_rdata;
        else if (st_fill)          cpu_rdata = asm_line[cpu_wsel];
    end

    // Bus side: reads own the bus outside idle, otherwise the buffer drains
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = wb_head.addr;
        bus_wdata = wb_head.data;
        unique case (state)
            ST_NCRD: begin bus_req = 1'b1; bus_addr = cpu_addr; end
            ST_FILL: begin bus_req = 1'b1; bus_addr = {fill_la, fill_cnt, 2'b00}; end
            default: begin bus_req = !wb_empty; bus_we = 1'b1; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            fill_la      <= '0;
            fill_way     <= 1'b0;
            fill_cnt     <= '0;
            fill_snooped <= 1'b0;
            fill_line    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_miss) begin
                    state        <= cpu_nc ? ST_NCRD : ST_FILL;
                    fill_la      <= cpu_la;
                    fill_way     <= victim_way;
                    fill_cnt     <= '0;
                    fill_snooped <= 1'b0;
                end
                ST_NCRD: if (bus_ack) state <= ST_IDLE;
                ST_FILL: begin
                    if (snp_on_fill) fill_snooped <= 1'b1;
                    if (bus_ack) begin
                        fill_line[fill_cnt] <= bus_rdata;
                        fill_cnt            <= fill_cnt + 1'b1;
                        if (fill_last) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk
    import cache_pkg::*;
#(
    parameter int WB_DEPTH = 4,
    localparam int CW = $clog2(WB_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_nc,
    input logic [LA_W-1:0]   cpu_la,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              snp_valid,
    input logic [LA_W-1:0]   snp_line,
    input logic              st_idle,
    input logic              st_fill,
    input logic [CW-1:0]     wb_level
);
    p_bus_hold_r9: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    p_read_after_drain_r6: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_we |-> wb_level == '0);

    p_write_zero_wait_r3: assert property (@(posedge clk) disable iff (rst)
        st_idle && cpu_req && cpu_we && wb_level < CW'(WB_DEPTH) |-> cpu_ready);

    p_snoop_invalidates_r7: assert property (@(posedge clk) disable iff (rst)
        st_idle && $past(snp_valid) && cpu_req && !cpu_we && !cpu_nc &&
        cpu_la == $past(snp_line) |-> !cpu_ready);

    p_fill_word_reads_r5: assert property (@(posedge clk) disable iff (rst)
        st_fill && bus_req |-> !bus_we && bus_addr[1:0] == 2'b00);
endmodule

bind cache_ctrl cache_ctrl_chk #(.WB_DEPTH(WB_DEPTH)) chk_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_nc(cpu_nc),
    .cpu_la(cpu_la), .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .snp_valid(snp_valid),
    .snp_line(snp_line), .st_idle(st_idle), .st_fill(st_fill), .wb_level(wb_level)
);

// File: tb/cache_ctrl_tb_top.sv
module cache_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_two_way = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_nc = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        snp_valid = 1'b0;
    logic [27:0] snp_line = '0;

    int n_run = 0, n_fail = 0, cyc = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] wlog_a[$], wlog_d[$], rlog_a[$];

    always #10 clk = ~clk;   // 50 MHz

    cache_ctrl dut_i (.*);

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    // Bus memory: ack one cycle after a request is seen
    always @(posedge clk) begin
        if (rst) bus_ack <= 1'b0;
        else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                mem[bus_addr] = bus_wdata;
                wlog_a.push_back(bus_addr);
                wlog_d.push_back(bus_wdata);
            end else begin
                rlog_a.push_back(bus_addr);
                bus_rdata <= mem.exists(bus_addr) ? mem[bus_addr] : pat(bus_addr);
            end
        end else bus_ack <= 1'b0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog (all R) actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic do_reset(input logic two_way);
        @(negedge clk);
        rst = 1'b1; cfg_two_way = two_way;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mem.delete();
    endtask

    task automatic access(input logic we, nc, input logic [31:0] a, d,
                          output logic [31:0] q, output int waits);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_nc = nc; cpu_addr = a; cpu_wdata = d;
        waits = 0;
        #1;
        while (!cpu_ready && waits < 400) begin
            @(negedge clk); #1; waits++;
        end
        q = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_nc = 1'b0;
    endtask

    task automatic snoop(input logic [31:0] a);
        @(negedge clk); snp_valid = 1'b1; snp_line = a[31:4];
        @(negedge clk); snp_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        #1;
        chk(cpu_ready == 1'b0, "R1 ready idle", 32'(cpu_ready), 0);
        chk(bus_req == 1'b0, "R1 bus idle", 32'(bus_req), 0);
    endtask

    // Fill, hit, other word of line, fill address order; index bits in one-way mode
    task automatic t_direct();
        logic [31:0] q; int w;
        do_reset(1'b0);
        rlog_a.delete();
        access(0, 0, 32'h0000_1008, 0, q, w);
        chk(w > 0, "R5 miss waits", w, 1);
        chk(q == pat(32'h0000_1008), "R5 miss data", q, pat(32'h0000_1008));
        chk(rlog_a.size() == 4 && rlog_a[0] == 32'h1000 && rlog_a[1] == 32'h1004 &&
            rlog_a[2] == 32'h1008 && rlog_a[3] == 32'h100C, "R5 fill order",
            rlog_a.size() > 0 ? rlog_a[0] : 0, 32'h1000);
        rlog_a.delete();
        access(0, 0, 32'h0000_100C, 0, q, w);
        chk(w == 0 && q == pat(32'h100C), "R2 hit other word", q, pat(32'h100C));
        chk(rlog_a.size() == 0, "R2 no bus on hit", rlog_a.size(), 0);
        access(0, 0, 32'h0000_5000, 0, q, w);   // bit 14 differs: separate index
        access(0, 0, 32'h0000_1000, 0, q, w);
        chk(w == 0, "R11 bit14 coexist", w, 0);
        access(0, 0, 32'h0000_9000, 0, q, w);   // same index, new tag: evicts
        access(0, 0, 32'h0000_1000, 0, q, w);
        chk(w > 0, "R11 conflict evicts", w, 1);
    endtask

    task automatic t_two_way();
        logic [31:0] q; int w;
        do_reset(1'b1);
        access(0, 0, 32'h0000_1000, 0, q, w);
        access(0, 0, 32'h0000_5000, 0, q, w);
        access(0, 0, 32'h0000_1000, 0, q, w);
        chk(w == 0, "R12 both ways held", w, 0);
        access(0, 0, 32'h0000_9000, 0, q, w);   // replaces 5000 (LRU)
        chk(w > 0 && q == pat(32'h9000), "R12 third miss", q, pat(32'h9000));
        access(0, 0, 32'h0000_1000, 0, q, w);
        chk(w == 0, "R12 MRU kept", w, 0);
        access(0, 0, 32'h0000_5000, 0, q, w);
        chk(w > 0, "R12 LRU evicted", w, 1);
    endtask

    task automatic t_writes();
        logic [31:0] q; int w;
        do_reset(1'b0);
        access(0, 0, 32'h0000_2000, 0, q, w);
        access(1, 0, 32'h0000_2004, 32'hCAFE_0001, q, w);
        chk(w == 0, "R3 write zero wait", w, 0);
        access(0, 0, 32'h0000_2004, 0, q, w);
        chk(w == 0 && q == 32'hCAFE_0001, "R4 write hit updates", q, 32'hCAFE_0001);
        repeat (10) @(negedge clk);
        chk(mem.exists(32'h2004) && mem[32'h2004] == 32'hCAFE_0001, "R3 written through",
            mem.exists(32'h2004) ? mem[32'h2004] : 0, 32'hCAFE_0001);
        access(1, 0, 32'h0000_3000, 32'hBEEF_0002, q, w);
        access(0, 0, 32'h0000_3000, 0, q, w);
        chk(w > 0, "R4 write miss no allocate", w, 1);
        chk(q == 32'hBEEF_0002, "R6 read sees drained write", q, 32'hBEEF_0002);
    endtask

    task automatic t_burst();
        logic [31:0] q; int w; int zw = 0;
        do_reset(1'b0);
        wlog_a.delete(); wlog_d.delete();
        for (int i = 0; i < 4; i++) begin
            access(1, i[0], 32'h0000_4000 + 32'(4 * i), 32'h1000_0000 + 32'(i), q, w);
            if (w == 0) zw++;
        end
        chk(zw == 4, "R3 four posted zero wait", zw, 4);
        repeat (20) @(negedge clk);
        begin
            bit ok = (wlog_a.size() == 4);
            for (int i = 0; i < 4 && ok; i++)
                ok = (wlog_a[i] == 32'h4000 + 32'(4 * i)) && (wlog_d[i] == 32'h1000_0000 + 32'(i));
            chk(ok, "R3 drain order", wlog_a.size(), 4);
        end
    endtask

    task automatic t_noncache();
        logic [31:0] q; int w;
        do_reset(1'b0);
        rlog_a.delete();
        access(0, 1, 32'h0000_6004, 0, q, w);
        chk(w > 0 && q == pat(32'h6004) && rlog_a.size() == 1, "R10 nc single read",
            rlog_a.size(), 1);
        access(0, 0, 32'h0000_6004, 0, q, w);
        chk(w > 0, "R10 nc no allocate", w, 1);
        access(1, 1, 32'h0000_6004, 32'h7777_0000, q, w);
        chk(w == 0, "R10 nc write posted", w, 0);
        access(0, 0, 32'h0000_6004, 0, q, w);
        chk(w == 0 && q == pat(32'h6004), "R10 nc write leaves line", q, pat(32'h6004));
        access(0, 1, 32'h0000_6004, 0, q, w);
        chk(q == 32'h7777_0000, "R10 nc write reached bus", q, 32'h7777_0000);
    endtask

    task automatic t_snoop();
        logic [31:0] q; int w;
        do_reset(1'b0);
        access(0, 0, 32'h0000_7000, 0, q, w);
        snoop(32'h0000_F000);                  // same index, other tag
        access(0, 0, 32'h0000_7000, 0, q, w);
        chk(w == 0, "R7 other tag untouched", w, 0);
        snoop(32'h0000_7008);
        access(0, 0, 32'h0000_7000, 0, q, w);
        chk(w > 0, "R7 snoop invalidates", w, 1);
        fork
            access(0, 0, 32'h0000_8004, 0, q, w);
            begin repeat (3) @(negedge clk); snoop(32'h0000_8000); end
        join
        chk(q == pat(32'h8004), "R8 fill still returns", q, pat(32'h8004));
        access(0, 0, 32'h0000_8004, 0, q, w);
        chk(w > 0, "R8 snooped fill invalid", w, 1);
    endtask

    initial begin
        t_reset();
        t_direct();
        t_two_way();
        t_writes();
        t_burst();
        t_noncache();
        t_snoop();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule